// File: doc/BRIEF.md
# TLB entry staging register interface

This block gives a processor access to the translation-table entries of a memory management unit through a handful of special registers. The special-register space is banked four ways. The active bank is chosen by a small bank register. Two of the banks reach MMU state, and each of those two owns a separate entry array of four sets by sixteen entries. Every entry is a pair of 32-bit words: a high word that carries the virtual page and a low word that carries the attributes, including a valid flag.

Software writes the selection register to point at one entry. A write to the high staging register also loads the fault-cause register, and that register serves as the hidden high word for the next commit. A write to the low staging register then stores the low word and the held high word into the selected entry. If the entry being replaced was valid, the block raises a one-cycle page-invalidate request that carries the old virtual page number, so that cached translations can be dropped. Any special-register read in an MMU bank first refreshes both staging mirrors from the selected entry and then returns the requested register one cycle after the strobe.

Top module: `tlb_access_regs`

## Requirements
- R1: After reset every special register in every bank and every word of both entry arrays reads as zero, the active bank is 0, and `sr_rvalid` and `flush_req` are low.
- R2: The active bank is the 2-bit value last written through `bank_we`/`bank_wdata`. It applies from the cycle after the write, so an access in the same cycle as a bank write uses the previous bank.
- R3: In banks 0 and 3 a write to any index only stores that value in the bank's own register. It never changes the cause register or an entry, never raises `flush_req`, and a read returns the stored value unchanged.
- R4: The selection register is special index 3 of the active MMU bank. Bits [3:0] pick the entry, bits [5:4] pick the set, and the remaining bits have no effect on which entry is addressed.
- R5: In banks 1 and 2 a write to index 6 (high staging) stores the value at index 6 and also at index 7 (fault cause) of the same bank.
- R6: In banks 1 and 2 a write to index 5 (low staging) stores the value at index 5 and commits the selected entry: the low word takes the written data and the high word takes the bank's index 7 value. Bank 1 uses entry array 0 and bank 2 uses entry array 1.
- R7: When a commit replaces an entry whose old low word has bit 3 set, `flush_req` is high for exactly the cycle after the write strobe, and `flush_vpage` equals bits [31:13] of the old high word. A commit over an entry with bit 3 clear raises no request. Commits on consecutive cycles each raise their own request.
- R8: A read in bank 1 or 2 reloads index 6 with the selected entry's high word and index 5 with its low word, whatever index is read, and the returned value already reflects the reload. Index 7 is not touched by a read.
- R9: `sr_rvalid` is high exactly one cycle after each read strobe that has no write strobe beside it. `sr_rdata` carries the read value in that cycle and holds it until the next read.
- R10: When `sr_we` and `sr_re` are high together, the write takes place and the read is dropped: no `sr_rvalid` follows and no mirror reload occurs.
- R11: The two entry arrays are independent. A commit through one bank leaves the same set and entry seen through the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_we | input | 1 | Load the bank register |
| bank_wdata | input | 2 | New active bank number |
| sr_we | input | 1 | Special-register write strobe |
| sr_re | input | 1 | Special-register read strobe |
| sr_addr | input | 4 | Special-register index within the active bank |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data, valid with `sr_rvalid` and held afterwards |
| sr_rvalid | output | 1 | Read data strobe, one cycle after the read |
| flush_req | output | 1 | One-cycle page-invalidate request |
| flush_vpage | output | 19 | Virtual page number to invalidate |

## Verification
The bench builds the block with its default parameters: four sets of sixteen entries, four banks of sixteen special registers, and two MMU arrays. With these values all 64 slots of each array can be reached by a selection value, including set bits that the bench sets together with junk in the upper bits. A pseudo-random stretch mixes bank changes, selection writes, high and low writes and reads. It drives valid-over-valid commits, back-to-back flushes and collisions between read and write, and it uses the passive banks 0 and 3 to show that the same indices do nothing there. All of this is compared on every cycle against a behavioural model that keeps the staging registers and entries in plain arrays.

// File: rtl/tlb_access_pkg.sv
package tlb_access_pkg;

  localparam int DATA_W      = 32;
  localparam int BANK_W      = 2;
  localparam int NUM_BANKS   = 1 << BANK_W;
  localparam int SREG_AW     = 4;
  localparam int NUM_SREGS   = 1 << SREG_AW;
  localparam int TLB_SETS    = 4;
  localparam int TLB_ENTRIES = 16;
  localparam int MMU_FIRST   = 1;
  localparam int NUM_MMU     = 2;
  localparam int ARR_W       = (NUM_MMU > 1) ? $clog2(NUM_MMU) : 1;
  localparam int VALID_BIT   = 3;
  localparam int PAGE_LSB    = 13;
  localparam int VPAGE_W     = DATA_W - PAGE_LSB;

  // special-register indices decoded inside an MMU bank
  localparam logic [SREG_AW-1:0] SR_SEL   = 4'd3;
  localparam logic [SREG_AW-1:0] SR_LO    = 4'd5;
  localparam logic [SREG_AW-1:0] SR_HI    = 4'd6;
  localparam logic [SREG_AW-1:0] SR_CAUSE = 4'd7;

  typedef struct packed {
    logic [DATA_W-1:0] hi;
    logic [DATA_W-1:0] lo;
  } tlb_entry_t;

  // true for banks that reach an entry array
  function automatic logic is_mmu_bank(input logic [BANK_W-1:0] b);
    return (int'(b) >= MMU_FIRST) && (int'(b) < MMU_FIRST + NUM_MMU);
  endfunction

  // entry array owned by an MMU bank
  function automatic logic [ARR_W-1:0] mmu_array(input logic [BANK_W-1:0] b);
    return ARR_W'(int'(b) - MMU_FIRST);
  endfunction

  function automatic logic entry_valid(input tlb_entry_t e);
    return e.lo[VALID_BIT];
  endfunction

  function automatic logic [VPAGE_W-1:0] entry_vpage(input tlb_entry_t e);
    return e.hi[DATA_W-1:PAGE_LSB];
  endfunction

  // value returned by a read: the staging words come from the entry
  function automatic logic [DATA_W-1:0] read_pick(input logic [SREG_AW-1:0] addr,
                                                  input logic mmu,
                                                  input tlb_entry_t e,
                                                  input logic [DATA_W-1:0] stored);
    if (mmu && addr == SR_HI) return e.hi;
    if (mmu && addr == SR_LO) return e.lo;
    return stored;
  endfunction

endpackage

// File: rtl/tlb_sreg_bank.sv
module tlb_sreg_bank
  import tlb_access_pkg::*;
#(
  parameter  int NB     = NUM_BANKS,
  parameter  int NR     = NUM_SREGS,
  parameter  int SLOT_W = 6,
  localparam int TOTAL  = NB * NR
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BANK_W-1:0]  bank,
  input  logic               wr_en,
  input  logic [SREG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               cause_en,
  input  logic [DATA_W-1:0]  cause_data,
  input  logic               mirror_en,
  input  tlb_entry_t         mirror_entry,
  input  logic [SREG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [SLOT_W-1:0]  sel_slot,
  output logic [DATA_W-1:0]  cause_q
);

  logic [TOTAL*DATA_W-1:0] flat;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [BANK_W-1:0] B_ID = BANK_W'(b);
    logic here;
    assign here = (bank == B_ID);
    for (genvar r = 0; r < NR; r++) begin : g_reg
      localparam logic [SREG_AW-1:0] R_ID = SREG_AW'(r);
      logic [DATA_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          val_q <= '0;
        else if (here && wr_en && wr_addr == R_ID)
          val_q <= wr_data;
        else if (here && cause_en && R_ID == SR_CAUSE)
          val_q <= cause_data;
        else if (here && mirror_en && R_ID == SR_HI)
          val_q <= mirror_entry.hi;
        else if (here && mirror_en && R_ID == SR_LO)
          val_q <= mirror_entry.lo;
      end
      assign flat[(b*NR + r)*DATA_W +: DATA_W] = val_q;
    end
  end

  assign rd_data  = flat[(int'(bank)*NR + int'(rd_addr))*DATA_W +: DATA_W];
  assign sel_slot = flat[(int'(bank)*NR + int'(SR_SEL))*DATA_W +: SLOT_W];
  assign cause_q  = flat[(int'(bank)*NR + int'(SR_CAUSE))*DATA_W +: DATA_W];

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_access_pkg::*;
#(
  parameter  int NUM_ARR  = NUM_MMU,
  parameter  int NSETS    = TLB_SETS,
  parameter  int NENTRIES = TLB_ENTRIES,
  localparam int SLOTS    = NSETS * NENTRIES,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int AW       = (NUM_ARR > 1) ? $clog2(NUM_ARR) : 1,
  localparam int ENTRY_W  = $bits(tlb_entry_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     arr,
  input  logic [SLOT_W-1:0] slot,
  input  logic              wr_en,
  input  tlb_entry_t        wr_entry,
  output tlb_entry_t        rd_entry
);

  logic [NUM_ARR*ENTRY_W-1:0] rd_flat;

  for (genvar a = 0; a < NUM_ARR; a++) begin : g_arr
    localparam logic [AW-1:0] A_ID = AW'(a);
    tlb_entry_t mem_q [SLOTS];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SLOTS; s++) mem_q[s] <= '0;
      end else if (wr_en && arr == A_ID) begin
        mem_q[slot] <= wr_entry;
      end
    end
    assign rd_flat[a*ENTRY_W +: ENTRY_W] = mem_q[slot];
  end

  assign rd_entry = rd_flat[int'(arr)*ENTRY_W +: ENTRY_W];

endmodule

// File: rtl/tlb_access_regs.sv
module tlb_access_regs
  import tlb_access_pkg::*;
#(
  parameter  int NSETS    = TLB_SETS,
  parameter  int NENTRIES = TLB_ENTRIES,
  localparam int SLOT_W   = $clog2(NSETS * NENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bank_we,
  input  logic [BANK_W-1:0]  bank_wdata,
  input  logic               sr_we,
  input  logic               sr_re,
  input  logic [SREG_AW-1:0] sr_addr,
  input  logic [DATA_W-1:0]  sr_wdata,
  output logic [DATA_W-1:0]  sr_rdata,
  output logic               sr_rvalid,
  output logic               flush_req,
  output logic [VPAGE_W-1:0] flush_vpage
);

  logic [BANK_W-1:0] bank_q;
  logic              mmu_bank;
  logic [ARR_W-1:0]  arr_sel;
  logic [SLOT_W-1:0] slot_sel;
  logic [DATA_W-1:0] sreg_rd;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] rd_next;
  tlb_entry_t        old_entry;
  tlb_entry_t        new_entry;

  // named events
  logic wr_hi_ev, commit_ev, read_ev, reload_ev, evict_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_we) bank_q <= bank_wdata;
  end

  assign mmu_bank  = is_mmu_bank(bank_q);
  assign arr_sel   = mmu_array(bank_q);
  assign wr_hi_ev  = sr_we && mmu_bank && (sr_addr == SR_HI);
  assign commit_ev = sr_we && mmu_bank && (sr_addr == SR_LO);
  assign read_ev   = sr_re && !sr_we;
  assign reload_ev = read_ev && mmu_bank;
  assign evict_ev  = commit_ev && entry_valid(old_entry);
  assign new_entry = '{hi: cause_q, lo: sr_wdata};
  assign rd_next   = read_pick(sr_addr, mmu_bank, old_entry, sreg_rd);

  tlb_sreg_bank #(
    .NB     (NUM_BANKS),
    .NR     (NUM_SREGS),
    .SLOT_W (SLOT_W)
  ) u_sregs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank         (bank_q),
    .wr_en        (sr_we),
    .wr_addr      (sr_addr),
    .wr_data      (sr_wdata),
    .cause_en     (wr_hi_ev),
    .cause_data   (sr_wdata),
    .mirror_en    (reload_ev),
    .mirror_entry (old_entry),
    .rd_addr      (sr_addr),
    .rd_data      (sreg_rd),
    .sel_slot     (slot_sel),
    .cause_q      (cause_q)
  );

  tlb_entry_store #(
    .NUM_ARR  (NUM_MMU),
    .NSETS    (NSETS),
    .NENTRIES (NENTRIES)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .arr      (arr_sel),
    .slot     (slot_sel),
    .wr_en    (commit_ev),
    .wr_entry (new_entry),
    .rd_entry (old_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_rvalid   <= 1'b0;
      sr_rdata    <= '0;
      flush_req   <= 1'b0;
      flush_vpage <= '0;
    end else begin
      sr_rvalid <= read_ev;
      if (read_ev) sr_rdata <= rd_next;
      flush_req <= evict_ev;
      if (evict_ev) flush_vpage <= entry_vpage(old_entry);
    end
  end

endmodule

// File: rtl/tlb_access_chk.sv
module tlb_access_chk
  import tlb_access_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bank_we,
  input logic [BANK_W-1:0]  bank_wdata,
  input logic               sr_we,
  input logic               sr_re,
  input logic [SREG_AW-1:0] sr_addr,
  input logic [DATA_W-1:0]  sr_wdata,
  input logic               sr_rvalid,
  input logic               flush_req,
  input logic [BANK_W-1:0]  bank_q,
  input logic [DATA_W-1:0]  cause_q
);

  AST_BANK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> bank_q == $past(bank_wdata)); // R2

  AST_PASSIVE_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && !is_mmu_bank(bank_q)) |=> !flush_req); // R3

  AST_HI_LOADS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && is_mmu_bank(bank_q) && sr_addr == SR_HI) |=> cause_q == $past(sr_wdata)); // R5

  AST_FLUSH_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> ($past(sr_we) && $past(sr_addr) == SR_LO && is_mmu_bank($past(bank_q)))); // R7

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_re && !sr_we) |=> sr_rvalid); // R9

  AST_RVALID_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sr_rvalid |-> $past(sr_re && !sr_we)); // R9

  AST_COLLIDE_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_re && sr_we) |=> !sr_rvalid); // R10

endmodule

bind tlb_access_regs tlb_access_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bank_we    (bank_we),
  .bank_wdata (bank_wdata),
  .sr_we      (sr_we),
  .sr_re      (sr_re),
  .sr_addr    (sr_addr),
  .sr_wdata   (sr_wdata),
  .sr_rvalid  (sr_rvalid),
  .flush_req  (flush_req),
  .bank_q     (bank_q),
  .cause_q    (cause_q)
);

// File: tb/test_tlb_access_regs.sv
module test_tlb_access_regs;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_we = 1'b0;
  logic [1:0]  bank_wdata = '0;
  logic        sr_we = 1'b0;
  logic        sr_re = 1'b0;
  logic [3:0]  sr_addr = '0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] sr_rdata;
  logic        sr_rvalid;
  logic        flush_req;
  logic [18:0] flush_vpage;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_access_regs i_tlb_access_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_we     (bank_we),
    .bank_wdata  (bank_wdata),
    .sr_we       (sr_we),
    .sr_re       (sr_re),
    .sr_addr     (sr_addr),
    .sr_wdata    (sr_wdata),
    .sr_rdata    (sr_rdata),
    .sr_rvalid   (sr_rvalid),
    .flush_req   (flush_req),
    .flush_vpage (flush_vpage)
  );

  // behavioural reference: plain arrays indexed by bank, array and slot
  logic [31:0] m_sr [4][16];
  logic [31:0] m_hi [2][64];
  logic [31:0] m_lo [2][64];
  int          m_bank;
  logic        e_rvalid, e_flush;
  logic [31:0] e_rdata;
  logic [18:0] e_vpage;

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 1'b0;
  bit    live    = 1'b0;
  string tag     = "R1";

  always @(posedge clk) begin : model
    int b, a, k;
    logic [31:0] sel;
    bit mmu;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) for (int j = 0; j < 16; j++) m_sr[i][j] = '0;
      for (int i = 0; i < 2; i++) for (int j = 0; j < 64; j++) begin
        m_hi[i][j] = '0; m_lo[i][j] = '0;
      end
      m_bank = 0; e_rvalid = 1'b0; e_flush = 1'b0; e_rdata = '0; e_vpage = '0;
    end else begin
      b   = m_bank;
      mmu = (b == 1) || (b == 2);
      a   = mmu ? b - 1 : 0;
      sel = m_sr[b][3];
      k   = int'((sel >> 4) & 32'd3) * 16 + int'(sel & 32'd15);
      e_rvalid = 1'b0;
      e_flush  = 1'b0;
      if (bank_we) m_bank = int'(bank_wdata);
      if (sr_we) begin
        if (mmu && sr_addr == 4'd5) begin
          if (m_lo[a][k][3]) begin
            e_flush = 1'b1;
            e_vpage = m_hi[a][k][31:13];
          end
          m_lo[a][k] = sr_wdata;
          m_hi[a][k] = m_sr[b][7];
        end
        if (mmu && sr_addr == 4'd6) m_sr[b][7] = sr_wdata;
        m_sr[b][sr_addr] = sr_wdata;
      end else if (sr_re) begin
        if (mmu) begin
          m_sr[b][6] = m_hi[a][k];
          m_sr[b][5] = m_lo[a][k];
        end
        e_rvalid = 1'b1;
        e_rdata  = m_sr[b][sr_addr];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      check(sr_rvalid === e_rvalid, "R9", 32'(sr_rvalid), 32'(e_rvalid));
      if (e_rvalid) check(sr_rdata === e_rdata, tag, sr_rdata, e_rdata);
      check(flush_req === e_flush, "R7", 32'(flush_req), 32'(e_flush));
      if (e_flush) check(flush_vpage === e_vpage, "R7", 32'(flush_vpage), 32'(e_vpage));
    end
  end

  task automatic drive(input bit we, input bit re, input logic [3:0] addr,
                       input logic [31:0] data, input bit bwe, input logic [1:0] bdata);
    @(negedge clk);
    sr_we = we; sr_re = re; sr_addr = addr; sr_wdata = data;
    bank_we = bwe; bank_wdata = bdata;
  endtask

  task automatic wr(input logic [3:0] addr, input logic [31:0] data);
    drive(1'b1, 1'b0, addr, data, 1'b0, 2'd0);
  endtask

  task automatic rd(input logic [3:0] addr);
    drive(1'b0, 1'b1, addr, 32'h0, 1'b0, 2'd0);
  endtask

  task automatic set_bank(input logic [1:0] v);
    drive(1'b0, 1'b0, 4'd0, 32'h0, 1'b1, v);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 2'd0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin : stim
    logic [31:0] seed;
    seed = 32'h1d2c3b4a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: outputs quiet straight after reset
    check(sr_rvalid === 1'b0, "R1", 32'(sr_rvalid), 32'h0);
    check(flush_req === 1'b0, "R1", 32'(flush_req), 32'h0);
    check(sr_rdata === 32'h0, "R1", sr_rdata, 32'h0);
    live = 1'b1;
    tag = "R1";
    rd(4'd3); rd(4'd7);
    set_bank(2'd1); rd(4'd5); rd(4'd6); rd(4'd9);

    // R3: passive banks store only
    tag = "R3";
    set_bank(2'd0);
    wr(4'd5, 32'hffff_ffff); wr(4'd6, 32'h1357_9bdf); wr(4'd3, 32'h0000_0011);
    rd(4'd5); rd(4'd6); rd(4'd7);
    set_bank(2'd3);
    wr(4'd5, 32'h0000_0008); wr(4'd5, 32'h0000_0000); rd(4'd5);
    set_bank(2'd1); rd(4'd5); rd(4'd6);

    // R4, R5, R6: select with junk upper bits, stage hi, commit
    tag = "R5";
    wr(4'd3, 32'habcd_0025);
    wr(4'd6, 32'h1234_6000); rd(4'd7); rd(4'd6);
    tag = "R6";
    wr(4'd5, 32'h0000_0008);
    rd(4'd5); rd(4'd6);
    tag = "R4";
    wr(4'd3, 32'h0000_0005); rd(4'd5);
    wr(4'd3, 32'hffff_ff25); rd(4'd5); rd(4'd6);

    // R7: valid replaced, back-to-back commits, then invalid replaced
    tag = "R7";
    wr(4'd6, 32'hffff_e000);
    wr(4'd5, 32'h0000_0009);
    wr(4'd5, 32'h0000_0000);
    wr(4'd5, 32'h0000_0000);
    idle(); rd(4'd6);

    // R8: mirrors reload on a read of another index; cause untouched
    tag = "R8";
    wr(4'd6, 32'hdead_beef); wr(4'd5, 32'h5555_5555);
    wr(4'd6, 32'h0f0f_0000);
    rd(4'd3); rd(4'd6); rd(4'd5); rd(4'd7);

    // R11: bank 2 owns the other array
    tag = "R11";
    set_bank(2'd2);
    wr(4'd3, 32'h0000_0025); rd(4'd6); rd(4'd5);
    wr(4'd6, 32'h2222_4000); wr(4'd5, 32'h0000_000c);
    set_bank(2'd1); rd(4'd6); rd(4'd5);
    set_bank(2'd2); rd(4'd6);

    // R2: bank write with an access in the same cycle uses the old bank
    tag = "R2";
    drive(1'b0, 1'b1, 4'd6, 32'h0, 1'b1, 2'd0);
    rd(4'd6);
    drive(1'b1, 1'b0, 4'd5, 32'h0000_0008, 1'b1, 2'd1);
    rd(4'd5);

    // R10: collision of write and read
    tag = "R10";
    drive(1'b1, 1'b1, 4'd6, 32'h7777_8000, 1'b0, 2'd0);
    idle(); rd(4'd7);

    // mixed traffic
    tag = "R6";
    for (int n = 0; n < 600; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      case (seed[19:17])
        3'd0: set_bank(seed[5:4]);
        3'd1: wr(4'd3, {seed[31:8], 2'b00, seed[7:6], seed[3:0]});
        3'd2: wr(4'd6, seed);
        3'd3, 3'd4: wr(4'd5, {seed[31:4], seed[21], seed[2:0]});
        3'd5: rd(seed[24:21]);
        3'd6: rd(seed[22] ? 4'd5 : 4'd6);
        default: drive(seed[23], 1'b1, seed[27:24], seed, 1'b0, 2'd0);
      endcase
    end
    idle(); idle();
    finish_run();
  end

endmodule